// File: doc/BRIEF.md
# Dual-Accumulator Montgomery Modular Multiplier

This block multiplies two multi-limb operands modulo an odd modulus and returns the Montgomery product A·B·2^(-W·N) mod M, where W is the limb width (32 by default) and N is the number of limbs. The block works limb-serially. For each limb of A, taken from least to most significant, it first forms a one-limb quotient digit. A product lane then adds the A limb times B into one accumulator. In parallel, a reduction lane adds the quotient digit times M into a second accumulator. Each lane handles one limb of its long operand per cycle. The running value is the difference of the two accumulators, so neither long multiply waits on the other.

The caller supplies A, B, M and the constant mu = +M^-1 mod 2^W, then pulses `start` while the block is idle. Once all limbs have been processed, one full-width subtraction forms the difference of the accumulators. A single conditional addition of M brings that difference into [0, M). The result is then registered and `done` pulses for one cycle. The result holds until the next accepted operation finishes.

Top module: `mont_dual_acc_mul`

## Requirements
- R1: For an odd M, operands A < M and B < M, and mu_in = M^-1 mod 2^W (positive sign), `result` equals A·B·2^(-W·N) mod M.
- R2: Every delivered `result` is strictly less than M.
- R3: In each outer step, the quotient digit makes the low limbs of the product-lane sum and the reduction-lane sum equal, so discarding them loses nothing. This holds also when the reduction accumulator's low limb exceeds the product accumulator's.
- R4: `done` is high for exactly one cycle. It rises N·(N+2)+1 clock cycles after the rising edge that accepted `start`.
- R5: A `start` pulse that arrives while an operation is in progress is ignored. The running operation's result and timing are unchanged.
- R6: While `done` is low, `result` does not change; it keeps the previous result.
- R7: After reset, `done` is 0 and `result` is 0.
- R8: If A or B is zero, `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| a_in | input | N_LIMBS*LIMB_W | Multiplier operand A, limb 0 in the low bits |
| b_in | input | N_LIMBS*LIMB_W | Multiplicand operand B |
| m_in | input | N_LIMBS*LIMB_W | Odd modulus M |
| mu_in | input | LIMB_W | M^-1 mod 2^LIMB_W |
| result | output | N_LIMBS*LIMB_W | Montgomery product, held between operations |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Zero operands and the pair A=B=1 separate the zero-product case from plain reduction of the constant 2^(-W·N). The all-ones modulus, with A=B=M-1, pushes every carry chain and both accumulators to their extremes. A modulus that fits in one limb, with zero upper limbs, shows whether the upper limbs of the reduction lane are carried correctly. Random full-width operands drive the final difference to both signs, which tests the conditional add of M. A start pulse in mid-operation, with different operands, shows whether the latched inputs are protected.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_QUOT = 2'd1,
      ST_MAC  = 2'd2,
      ST_FIN  = 2'd3
   } mm_state_e;

   localparam int NUM_LANES = 2;
   localparam int LANE_PROD = 0;
   localparam int LANE_RED  = 1;
endpackage

// File: rtl/mm_quot.sv
module mm_quot #(
   parameter int LW = 32
) (
   input  logic [LW-1:0] a_limb,
   input  logic [LW-1:0] b_low,
   input  logic [LW-1:0] e_low,
   input  logic [LW-1:0] f_low,
   input  logic [LW-1:0] mu,
   output logic [LW-1:0] q_digit
);
   logic [LW-1:0] t_low;

   always_comb begin
      t_low   = a_limb * b_low + e_low - f_low;
      q_digit = mu * t_low;
   end
endmodule

// File: rtl/mm_mac_lane.sv
module mm_mac_lane #(
   parameter int LW = 32
) (
   input  logic [LW-1:0] mul_x,
   input  logic [LW-1:0] mul_y,
   input  logic [LW-1:0] acc_in,
   input  logic [LW-1:0] carry_in,
   output logic [LW-1:0] sum_lo,
   output logic [LW-1:0] carry_out
);
   logic [2*LW-1:0] full;

   always_comb begin
      full = {{LW{1'b0}}, mul_x} * {{LW{1'b0}}, mul_y}
           + {{LW{1'b0}}, acc_in} + {{LW{1'b0}}, carry_in};
      sum_lo    = full[LW-1:0];
      carry_out = full[2*LW-1:LW];
   end
endmodule

// File: rtl/mm_final.sv
module mm_final #(
   parameter int LW = 32,
   parameter int NL = 4
) (
   input  logic [(NL+1)*LW-1:0] e_acc,
   input  logic [(NL+1)*LW-1:0] f_acc,
   input  logic [NL*LW-1:0]     modulus,
   output logic [(NL+1)*LW-1:0] corrected
);
   localparam int AW = (NL+1)*LW;
   logic [AW-1:0] diff;

   always_comb begin
      diff      = e_acc - f_acc;
      corrected = diff[AW-1] ? diff + {{LW{1'b0}}, modulus} : diff;
   end
endmodule

// File: rtl/mont_dual_acc_mul.sv
module mont_dual_acc_mul
   import mm_pkg::*;
#(
   parameter int LIMB_W  = 32,
   parameter int N_LIMBS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [N_LIMBS*LIMB_W-1:0]   a_in,
   input  logic [N_LIMBS*LIMB_W-1:0]   b_in,
   input  logic [N_LIMBS*LIMB_W-1:0]   m_in,
   input  logic [LIMB_W-1:0]           mu_in,
   output logic [N_LIMBS*LIMB_W-1:0]   result,
   output logic                        done
);
   localparam int OPW  = N_LIMBS * LIMB_W;
   localparam int ACCW = OPW + LIMB_W;
   localparam int IW   = $clog2(N_LIMBS + 1);
   localparam int JW   = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1;
   localparam logic [IW-1:0] I_LAST = IW'(N_LIMBS);
   localparam logic [JW-1:0] J_LAST = JW'(N_LIMBS - 1);

   initial begin
      a_cfg_limb_w : assert (LIMB_W >= 8) else $error("LIMB_W too small");
      a_cfg_limbs  : assert (N_LIMBS >= 1) else $error("N_LIMBS must be positive");
   end

   mm_state_e          st_q;
   logic [OPW-1:0]     a_q, b_q, m_q;
   logic [LIMB_W-1:0]  mu_q, q_q;
   logic [ACCW-1:0]    e_q, f_q;
   logic [IW-1:0]      i_q;
   logic [JW-1:0]      j_q;
   logic [LIMB_W-1:0]  cy_q [NUM_LANES];
   logic [OPW-1:0]     res_q;
   logic               done_q;

   logic [ACCW-1:0]    b_ext, m_ext;
   logic [LIMB_W-1:0]  a_limb, q_w;
   logic [IW-1:0]      slot;
   logic [ACCW-1:0]    corr_w;
   logic [LIMB_W-1:0]  ln_x [NUM_LANES];
   logic [LIMB_W-1:0]  ln_y [NUM_LANES];
   logic [LIMB_W-1:0]  ln_acc [NUM_LANES];
   logic [LIMB_W-1:0]  ln_cin [NUM_LANES];
   logic [LIMB_W-1:0]  ln_sum [NUM_LANES];
   logic [LIMB_W-1:0]  ln_cout [NUM_LANES];

   always_comb begin
      b_ext  = {{LIMB_W{1'b0}}, b_q};
      m_ext  = {{LIMB_W{1'b0}}, m_q};
      a_limb = a_q[j_q*LIMB_W +: LIMB_W];
      slot   = i_q - IW'(1);
      ln_x[LANE_PROD]   = a_limb;
      ln_y[LANE_PROD]   = b_ext[i_q*LIMB_W +: LIMB_W];
      ln_acc[LANE_PROD] = e_q[i_q*LIMB_W +: LIMB_W];
      ln_cin[LANE_PROD] = cy_q[LANE_PROD];
      ln_x[LANE_RED]    = q_q;
      ln_y[LANE_RED]    = m_ext[i_q*LIMB_W +: LIMB_W];
      ln_acc[LANE_RED]  = f_q[i_q*LIMB_W +: LIMB_W];
      ln_cin[LANE_RED]  = cy_q[LANE_RED];
   end

   mm_quot #(.LW(LIMB_W)) u_quot (
      .a_limb  (a_limb),
      .b_low   (b_q[LIMB_W-1:0]),
      .e_low   (e_q[LIMB_W-1:0]),
      .f_low   (f_q[LIMB_W-1:0]),
      .mu      (mu_q),
      .q_digit (q_w)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      mm_mac_lane #(.LW(LIMB_W)) u_lane (
         .mul_x     (ln_x[g]),
         .mul_y     (ln_y[g]),
         .acc_in    (ln_acc[g]),
         .carry_in  (ln_cin[g]),
         .sum_lo    (ln_sum[g]),
         .carry_out (ln_cout[g])
      );
   end

   mm_final #(.LW(LIMB_W), .NL(N_LIMBS)) u_final (
      .e_acc     (e_q),
      .f_acc     (f_q),
      .modulus   (m_q),
      .corrected (corr_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         m_q    <= '0;
         mu_q   <= '0;
         q_q    <= '0;
         e_q    <= '0;
         f_q    <= '0;
         i_q    <= '0;
         j_q    <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
         for (int k = 0; k < NUM_LANES; k++) cy_q[k] <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               a_q  <= a_in;
               b_q  <= b_in;
               m_q  <= m_in;
               mu_q <= mu_in;
               e_q  <= '0;
               f_q  <= '0;
               j_q  <= '0;
               st_q <= ST_QUOT;
            end
            ST_QUOT: begin
               q_q  <= q_w;
               i_q  <= '0;
               for (int k = 0; k < NUM_LANES; k++) cy_q[k] <= '0;
               st_q <= ST_MAC;
            end
            ST_MAC: begin
               for (int k = 0; k < NUM_LANES; k++) cy_q[k] <= ln_cout[k];
               if (i_q != '0) begin
                  for (int k = 0; k < N_LIMBS; k++) begin
                     if (slot == IW'(k)) begin
                        e_q[k*LIMB_W +: LIMB_W] <= ln_sum[LANE_PROD];
                        f_q[k*LIMB_W +: LIMB_W] <= ln_sum[LANE_RED];
                     end
                  end
               end
               if (i_q == I_LAST) begin
                  e_q[OPW +: LIMB_W] <= ln_cout[LANE_PROD];
                  f_q[OPW +: LIMB_W] <= ln_cout[LANE_RED];
                  if (j_q == J_LAST) begin
                     st_q <= ST_FIN;
                  end else begin
                     j_q  <= j_q + JW'(1);
                     st_q <= ST_QUOT;
                  end
               end else begin
                  i_q <= i_q + IW'(1);
               end
            end
            ST_FIN: begin
               res_q  <= corr_w[OPW-1:0];
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign result = res_q;
   assign done   = done_q;

   // R3: the quotient digit cancels the dropped low limbs of both lanes
   a_r3_low_cancel : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MAC && i_q == '0) |-> ln_sum[LANE_PROD] == ln_sum[LANE_RED]);

   // R2: the corrected difference never reaches the extra accumulator limb
   a_r2_top_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIN) |-> corr_w[ACCW-1:OPW] == '0);

   a_r2_below_mod : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> res_q < m_q);

   a_r4_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   a_r5_busy_start : assert property (@(posedge clk) disable iff (!rst_n)
      (start && (st_q == ST_QUOT || st_q == ST_MAC)) |=>
         ($stable(a_q) && $stable(b_q) && $stable(m_q) && st_q != ST_IDLE));

   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(res_q));
endmodule

// File: tb/tb_mont_dual_acc_mul.sv
module tb_mont_dual_acc_mul;
   localparam int LW  = 32;
   localparam int NL  = 4;
   localparam int OPW = NL * LW;
   localparam int LAT = NL * (NL + 2) + 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [OPW-1:0] a_in = '0, b_in = '0, m_in = '0;
   logic [LW-1:0]  mu_in = '0;
   logic [OPW-1:0] result;
   logic           done;

   int errors = 0;
   int checks = 0;
   logic           prev_done = 1'b0;
   logic [OPW-1:0] prev_res = '0;
   bit             mon_on = 1'b0;

   always #10 clk = ~clk;

   mont_dual_acc_mul #(.LIMB_W(LW), .N_LIMBS(NL)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .m_in(m_in), .mu_in(mu_in), .result(result), .done(done));

   task automatic chk(input bit ok, input string req, input logic [OPW-1:0] act,
                      input logic [OPW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] inv32(input logic [LW-1:0] m0);
      logic [LW-1:0] x;
      x = m0;
      for (int k = 0; k < 5; k++) x = x * (32'd2 - m0 * x);
      return x;
   endfunction

   // bit-serial halving model of A*B*2^-(LW*NL) mod M
   function automatic logic [OPW-1:0] mont_ref(input logic [OPW-1:0] a,
         input logic [OPW-1:0] b, input logic [OPW-1:0] m);
      logic [4*OPW-1:0] x;
      x = {{(3*OPW){1'b0}}, a} * {{(3*OPW){1'b0}}, b};
      for (int k = 0; k < OPW; k++) begin
         if (x[0]) x = x + {{(3*OPW){1'b0}}, m};
         x = x >> 1;
      end
      if (x >= {{(3*OPW){1'b0}}, m}) x = x - {{(3*OPW){1'b0}}, m};
      return x[OPW-1:0];
   endfunction

   function automatic logic [OPW-1:0] rnd_wide();
      logic [OPW-1:0] v;
      for (int k = 0; k < NL; k++) v[k*LW +: LW] = $urandom;
      return v;
   endfunction

   // per-cycle monitor: done width (R4) and result hold (R6)
   always @(negedge clk) begin
      if (mon_on) begin
         chk(!(prev_done && done), "R4 done longer than one cycle", {127'd0, done}, '0);
         if (!done) chk(result == prev_res, "R6 result changed without done", result, prev_res);
      end
      prev_done = done;
      prev_res  = result;
   end

   task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input logic [OPW-1:0] m, input int poke, input string tag);
      logic [OPW-1:0] exp;
      int c;
      int seen;
      exp = mont_ref(a, b, m);
      @(negedge clk);
      a_in = a; b_in = b; m_in = m; mu_in = inv32(m[LW-1:0]); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = -1;
      for (c = 1; c <= LAT + 20; c++) begin
         if (poke > 0 && c == poke + 1) start = 1'b0;
         if (done) begin seen = c - 1; break; end
         if (poke > 0 && c == poke) begin
            a_in = rnd_wide(); b_in = rnd_wide(); m_in = rnd_wide() | 1; start = 1'b1;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(seen == LAT, {"R4 latency ", tag}, OPW'(seen), OPW'(LAT));
      chk(result == exp, {"R1 product ", tag}, result, exp);
      chk(result < m, {"R2 below modulus ", tag}, result, m);
      repeat (3) @(negedge clk);
      chk(result == exp && !done, {"R6 held ", tag}, result, exp);
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [OPW-1:0] m, a, b;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R7 done after reset", {127'd0, done}, '0);
      chk(result == '0, "R7 result after reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_res = result;
      mon_on = 1'b1;

      m = rnd_wide() | {1'b1, {(OPW-1){1'b0}}} | 1;
      run_op('0, rnd_wide() % m, m, 0, "R8 A zero");
      chk(result == '0, "R8 A zero gives zero", result, '0);
      run_op(rnd_wide() % m, '0, m, 0, "R8 B zero");
      chk(result == '0, "R8 B zero gives zero", result, '0);
      run_op(1, 1, m, 0, "R1 unit operands");

      m = '1;
      run_op(m - 1, m - 1, m, 0, "R1 all-ones modulus");
      m = 7;
      run_op(6, 5, m, 0, "R1 one-limb modulus");
      m = {1'b1, {(OPW-2){1'b0}}, 1'b1};
      run_op(m - 1, 2, m, 0, "R1 sparse modulus");

      // R3: low limb of A small, B large, so the reduction lane leads
      m = rnd_wide() | 1;
      run_op({rnd_wide() % (m >> LW), 32'd1}, m - 1, m, 0, "R3 reduction lane ahead");

      for (int t = 0; t < 6; t++) begin
         m = rnd_wide() | 1;
         a = rnd_wide() % m;
         b = rnd_wide() % m;
         run_op(a, b, m, 0, "R1 random");
      end

      m = rnd_wide() | 1;
      run_op(rnd_wide() % m, rnd_wide() % m, m, 5, "R5 start while busy");
      run_op(rnd_wide() % m, rnd_wide() % m, m, LAT - 1, "R5 start just before done");

      mon_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule